// File: doc/BRIEF.md
# Dual-Modulus Fractional Tick Divider

This block produces a slow tick from a fast reference clock when the ratio between the two clocks is not an integer. A typical case is a tick of about 32768 Hz taken from a 24 MHz reference. The block switches between two integer divide ratios. First it counts out a set number of periods of the first length. Then it counts out a set number of periods of the second length. After that the whole pattern starts again. Over one full pattern, the average tick rate is the reference rate divided by (N0·M0 + N1·M1)/(M0 + M1).

Two 32-bit configuration words set the block up. The divide word holds a run enable bit, a mode field and both period lengths. The repeat word holds the two repeat counts. Every length and count field holds its value minus one. The output is a pulse one reference cycle wide, asserted in the last cycle of each period. The block keeps a private copy of the four fields and refreshes that copy only when it is idle or when a pattern ends. A pattern therefore always runs with one consistent ratio.

Top module: `frac_tick_div`

## Requirements
- R1: tick_o is high for exactly one reference cycle at the end of each period. A period lasts N reference cycles, where N is the length field plus one. A length field of 0 gives a tick in every cycle.
- R2: In cfg_div_i, the block runs only when bit 31 is 1 and bits 29:28 equal 1. The first length field sits at bits 11:0 and the second length field at bits 23:12.
- R3: In cfg_rep_i, the first repeat count sits at bits 11:0 and the second at bits 23:12. Each holds its count minus one.
- R4: While running, the block emits M0 periods of N0 cycles, then M1 periods of N1 cycles, and repeats this pattern. Each pattern gives exactly M0+M1 ticks in N0·M0+N1·M1 cycles.
- R5: While the block is not running, tick_o is low and the internal counters stay at their reset state. tick_o is low from the first clock edge at which a non-running configuration is sampled. After the block starts, the first tick comes N0 cycles after the edge that samples the enabling configuration, counting the cycle that follows that edge.
- R6: A change to any length or count field while running has no effect until the current pattern ends. The new values then govern the next pattern.
- R7: While rst_ni is low, tick_o is low.
- R8: With the fields 0x2DC, 0x2DB, 1 and 2, the block gives 5 ticks every 3662 cycles. From 24 MHz this averages about 32768 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_div_i | input | 32 | Divide word: run enable, mode and the two period lengths |
| cfg_rep_i | input | 32 | Repeat word: the two repeat counts |
| tick_o | output | 1 | Single-cycle tick at the end of each period |

## Verification
The assertions assume the configuration words are synchronous to clk_i. They also assume the run condition changes only between clock edges. The bench drives both words only on the falling edge, so every change is seen cleanly at the next rising edge. Random field values are kept small so that many complete patterns fit in the run. Mid-pattern rewrites and toggles of the enable and mode bits are mixed in, and the bench model follows when each change reaches the snapshot.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int FLD_W    = 12;
  localparam int CFG_W    = 32;
  localparam int EN_BIT   = 31;
  localparam int MODE_LSB = 28;
  localparam int MODE_W   = 2;
  localparam int MODE_RUN = 1;
  localparam int LO_LSB   = 0;
  localparam int HI_LSB   = 12;

  typedef struct packed {
    logic [FLD_W-1:0] n0;
    logic [FLD_W-1:0] n1;
    logic [FLD_W-1:0] m0;
    logic [FLD_W-1:0] m1;
  } ratio_t;

  function automatic ratio_t unpack_ratio(input logic [CFG_W-1:0] d, input logic [CFG_W-1:0] r);
    ratio_t x;
    x.n0 = d[LO_LSB +: FLD_W];
    x.n1 = d[HI_LSB +: FLD_W];
    x.m0 = r[LO_LSB +: FLD_W];
    x.m1 = r[HI_LSB +: FLD_W];
    return x;
  endfunction

  function automatic logic cfg_active(input logic [CFG_W-1:0] d);
    return d[EN_BIT] && (d[MODE_LSB +: MODE_W] == MODE_W'(MODE_RUN));
  endfunction
endpackage

// File: rtl/frac_div_period.sv
module frac_div_period #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] term_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R1: count never runs past the active period length
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term_i);

  // R1: a period end restarts the count
  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cnt_q == '0);
endmodule

// File: rtl/frac_div_phase.sv
module frac_div_phase #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] rep0_i,
  input  logic [W-1:0] rep1_i,
  output logic         sel_o,
  output logic         wrap_o
);
  logic [W-1:0] rep_q;
  logic         sel_q;
  logic [W-1:0] term;
  logic         last;

  assign term   = sel_q ? rep1_i : rep0_i;
  assign last   = step_i && (rep_q == term);
  assign sel_o  = sel_q;
  assign wrap_o = last && sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q <= '0;
      sel_q <= 1'b0;
    end else if (!en_i) begin
      rep_q <= '0;
      sel_q <= 1'b0;
    end else if (last) begin
      rep_q <= '0;
      sel_q <= ~sel_q;
    end else if (step_i) begin
      rep_q <= rep_q + 1'b1;
    end
  end

  // R4: repeat count stays inside the active phase's count
  p_rep_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_q <= term);

  // R4: switch to the second ratio only right after a period end
  p_rise_on_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_q) |-> $past(step_i));
endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
  import frac_div_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] cfg_div_i,
  input  logic [31:0] cfg_rep_i,
  output logic        tick_o
);
  logic   run_d, run_q;
  ratio_t snap_q;
  logic   sel, wrap, done;
  logic [FLD_W-1:0] n_term;

  assign run_d = cfg_active(cfg_div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  // idle or pattern end: take a fresh copy of the ratio fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              snap_q <= '0;
    else if (!run_q || wrap)  snap_q <= unpack_ratio(cfg_div_i, cfg_rep_i);
  end

  assign n_term = sel ? snap_q.n1 : snap_q.n0;

  frac_div_period #(.W(FLD_W)) u_period (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_q),
    .term_i (n_term),
    .done_o (done)
  );

  frac_div_phase #(.W(FLD_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_q),
    .step_i (done),
    .rep0_i (snap_q.m0),
    .rep1_i (snap_q.m1),
    .sel_o  (sel),
    .wrap_o (wrap)
  );

  assign tick_o = done;

  // R5: a non-running configuration silences the next cycle
  p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_d |=> !tick_o);

  // R6: ratio copy holds for the whole pattern
  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !wrap) |=> $stable(snap_q));

  // R7: reset leaves the output low
  always_comb begin
    if (!rst_ni) p_rst_low_r7: assert (!tick_o);
  end
endmodule

// File: tb/frac_tick_div_tb_top.sv
`timescale 1ns/1ps
module frac_tick_div_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] cfg_div_i = '0;
  logic [31:0] cfg_rep_i = '0;
  logic tick_o;

  int n_chk = 0, n_bad = 0, tick_cnt = 0;
  bit finished = 0;
  string tag_s = "R7";

  // model state: what the design holds after the last rising edge
  bit m_run = 0;
  int gap = 1, idx = 0;
  int e_n0 = 0, e_n1 = 0, e_m0 = 0, e_m1 = 0;

  always #2.5 clk_i = ~clk_i;

  frac_tick_div dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_div_i(cfg_div_i),
    .cfg_rep_i(cfg_rep_i), .tick_o(tick_o)
  );

  function automatic logic [31:0] mk_div(bit en, int mode, int n0f, int n1f);
    logic [31:0] w = '0;
    w[31] = en; w[29:28] = mode[1:0];
    w[11:0] = n0f[11:0]; w[23:12] = n1f[11:0];
    return w;
  endfunction

  function automatic logic [31:0] mk_rep(int m0f, int m1f);
    logic [31:0] w = '0;
    w[11:0] = m0f[11:0]; w[23:12] = m1f[11:0];
    return w;
  endfunction

  task automatic chk(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t tick actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic load_model();
    e_n0 = int'(cfg_div_i[11:0]);  e_n1 = int'(cfg_div_i[23:12]);
    e_m0 = int'(cfg_rep_i[11:0]);  e_m1 = int'(cfg_rep_i[23:12]);
  endtask

  // one cycle: check output, apply next stimulus, advance model over next edge
  task automatic cyc(logic [31:0] d, logic [31:0] r);
    int nn;
    bit exp;
    @(negedge clk_i);
    nn  = (idx < e_m0 + 1) ? e_n0 + 1 : e_n1 + 1;
    exp = m_run && (gap == nn);
    chk(tick_o, exp, tag_s);
    if (tick_o) tick_cnt++;
    cfg_div_i = d;
    cfg_rep_i = r;
    if (m_run) begin
      if (exp) begin
        gap = 1;
        if (idx == e_m0 + e_m1 + 1) begin idx = 0; load_model(); end
        else idx++;
      end else gap++;
    end else begin
      gap = 1; idx = 0; load_model();
    end
    m_run = cfg_div_i[31] && (cfg_div_i[29:28] == 2'd1);
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) cyc(cfg_div_i, cfg_rep_i);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r;
    // R7: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(tick_o, 1'b0, "R7");
    end
    rst_ni = 1'b1;
    hold(3);

    // R8: standard 24 MHz setting, two full patterns
    tag_s = "R8";
    cyc(mk_div(1, 1, 12'h2DC, 12'h2DB), mk_rep(1, 2));
    tick_cnt = 0;
    hold(7324);
    n_chk++;
    if (tick_cnt != 10) begin
      n_bad++;
      $display("FAIL R8 ticks in 7324 cycles actual=%0d expected=10", tick_cnt);
    end

    // R5: enable bit cleared
    tag_s = "R5";
    cyc(mk_div(0, 1, 2, 2), mk_rep(0, 0));
    tick_cnt = 0;
    hold(40);
    n_chk++;
    if (tick_cnt != 0) begin
      n_bad++;
      $display("FAIL R5 ticks while off actual=%0d expected=0", tick_cnt);
    end

    // R2: wrong mode values stay silent, mode 1 runs
    tag_s = "R2";
    for (int md = 0; md < 4; md++) begin
      cyc(mk_div(1, md, 3, 1), mk_rep(1, 1));
      tick_cnt = 0;
      hold(30);
      n_chk++;
      if ((md == 1) != (tick_cnt > 0)) begin
        n_bad++;
        $display("FAIL R2 mode=%0d ticks actual=%0d expected %s", md, tick_cnt, md == 1 ? ">0" : "0");
      end
      cyc(mk_div(0, 0, 0, 0), '0);
    end

    // R3: distinct repeat fields, pattern 3x2 then 1x7 = 13 cycles, 4 ticks
    tag_s = "R3";
    cyc(mk_div(1, 1, 1, 6), mk_rep(2, 0));
    tick_cnt = 0;
    hold(13);
    n_chk++;
    if (tick_cnt != 4) begin
      n_bad++;
      $display("FAIL R3 ticks in 13 cycles actual=%0d expected=4", tick_cnt);
    end
    hold(40);
    cyc(mk_div(0, 1, 0, 0), '0);

    // R1: length field 0 gives a tick every cycle
    tag_s = "R1";
    cyc(mk_div(1, 1, 0, 2), mk_rep(3, 1));
    hold(40);
    cyc(mk_div(0, 1, 0, 0), '0);

    // R6: rewrite mid-pattern
    tag_s = "R6";
    cyc(mk_div(1, 1, 3, 3), mk_rep(1, 1));
    hold(5);
    cyc(mk_div(1, 1, 0, 9), mk_rep(0, 2));
    hold(80);
    cyc(mk_div(0, 1, 0, 0), '0);

    // R4: random segments
    tag_s = "R4";
    void'($urandom(32'h5eed));
    for (int s = 0; s < 300; s++) begin
      d = mk_div(($urandom % 10) != 0, (($urandom % 5) == 0) ? int'($urandom % 4) : 1,
                 int'($urandom % 16), int'($urandom % 16));
      r = mk_rep(int'($urandom % 4), int'($urandom % 4));
      cyc(d, r);
      hold(20 + int'($urandom % 180));
    end
    hold(5);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule